// File: doc/BRIEF.md
# Handshaked Serial Command Engine

This block is the controller end of a byte-wide command and response exchange. A host moves one byte at a time through an 8-bit shift register and paces each byte with two active-low lines: `req_ni`, which the host drives, and `ack_no`, which the engine drives. The first byte of a transaction is a command code. A built-in length table then says how many argument bytes follow and how many response bytes go back. Either length can be marked variable. A variable argument length is carried in the byte that follows the command. A variable response length is sent to the host as the first response byte.

When all arguments have arrived, the engine raises `disp_req_o`. It presents the command code, the count of argument bytes received and the stored argument bytes to a dispatcher. It waits for `disp_ack_i` and takes the dispatcher's response into a local buffer. It then returns that response one byte per host request. Each byte that is consumed or produced gives a one-cycle strobe to the host-side interrupt logic. A direction that does not match the current phase gives a protocol-error pulse.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset `ack_no` is 1, the engine is idle, and `sr_done_o`, `proto_err_o` and `disp_req_o` are all 0.
- R2: A valid request is `req_ni` falling to 0 while `ack_no` is 1. The clock edge that samples it drives `ack_no` to 0 and processes exactly one byte. A request line that holds its level triggers no further processing.
- R3: `req_ni` rising to 1 while `ack_no` is 0 is a release. `ack_no` returns to 1 on the next edge and no byte is processed.
- R4: In idle with `sr_dir_i`=1 (host-to-block), the byte is taken as the command code. The {argument, response} lengths are looked up, with 8'hFF meaning variable: 8'h10 {1,0}, 8'h30 {4,0}, 8'h38 {0,4}, 8'h48 {0,1}, 8'h78 {0,FF}, and every other code {FF,FF}. An argument length of 0 dispatches at once.
- R5: With a fixed argument length N, the engine collects exactly N bytes and then dispatches. Argument byte i appears on `disp_args_o[8i+7:8i]`, and `disp_argc_o` equals N.
- R6: With a variable argument length, the first byte after the command is the argument count. A count of 0 dispatches at once.
- R7: Argument bytes beyond the 32-entry buffer are dropped but still counted. Dispatch happens when the received count reaches the argument length.
- R8: `disp_req_o` stays high until `disp_ack_i`. While it is high, handshake changes are deferred and `ack_no` does not change.
- R9: With a fixed response length N, the next N block-to-host requests (`sr_dir_i`=0) return response bytes 0..N-1 on `sr_data_o`, after which the engine is idle. If N=0, the engine goes idle straight from dispatch.
- R10: With a variable response length, the first response byte is the dispatcher's size (clamped to 32). The buffered bytes follow. A size of 0 ends the transaction after that byte.
- R11: If `disp_known_i`=0, a fixed response length yields that many zero bytes, and a variable one yields a size byte of 0 and nothing else.
- R12: A request with the wrong direction for the phase pulses `proto_err_o` and gives no strobe. The byte is not consumed and the phase is unchanged. Idle and argument phases need host-to-block; the response phase needs block-to-host.
- R13: `sr_done_o` pulses for one cycle for each byte consumed or produced, on the same edge that lowers `ack_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | Host request line, active low |
| ack_no | output | 1 | Engine acknowledge line, active low |
| sr_dir_i | input | 1 | Shift direction: 1 host-to-block, 0 block-to-host |
| sr_data_i | input | 8 | Byte shifted in by the host |
| sr_data_o | output | 8 | Byte offered to the host |
| sr_done_o | output | 1 | Shift-complete strobe |
| proto_err_o | output | 1 | Protocol-error pulse |
| disp_req_o | output | 1 | Command ready for the dispatcher |
| disp_cmd_o | output | 8 | Command code |
| disp_argc_o | output | 8 | Argument bytes received |
| disp_args_o | output | 256 | Stored argument bytes, byte i at bits 8i+7:8i |
| disp_ack_i | input | 1 | Dispatcher has finished; response is valid |
| disp_known_i | input | 1 | Dispatcher recognised the command |
| disp_rsp_len_i | input | 8 | Response size for a variable-length response |
| disp_rsp_i | input | 256 | Response bytes, byte i at bits 8i+7:8i |

## Verification
The assertions assume that `req_ni` is synchronous to `clk_i` and that the host changes it only after the previous change has been answered. They also assume that `sr_dir_i` and `sr_data_i` are stable on the edge that samples a falling request. The stimulus changes every input half a period away from the active edge. It holds each request low for one cycle before releasing it, and it pulses `disp_ack_i` for a single cycle while `disp_req_o` is high. Under these conditions the unreachable case of both lines low never arises. The ack-stability check during dispatch therefore compares only engine-driven states.

// File: rtl/hs_cmd_pkg.sv
package hs_cmd_pkg;

  localparam logic [7:0] LEN_VAR = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DISP,
    ST_RSP
  } eng_state_e;

  typedef struct packed {
    logic [7:0] arg_len;
    logic [7:0] rsp_len;
  } len_pair_t;

  function automatic len_pair_t lookup_len(input logic [7:0] code);
    len_pair_t p;
    case (code)
      8'h10:   p = '{arg_len: 8'd1, rsp_len: 8'd0};
      8'h30:   p = '{arg_len: 8'd4, rsp_len: 8'd0};
      8'h38:   p = '{arg_len: 8'd0, rsp_len: 8'd4};
      8'h48:   p = '{arg_len: 8'd0, rsp_len: 8'd1};
      8'h78:   p = '{arg_len: 8'd0, rsp_len: LEN_VAR};
      default: p = '{arg_len: LEN_VAR, rsp_len: LEN_VAR};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hs_cmd_handshake.sv
module hs_cmd_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic hold_i,
  output logic ack_no,
  output logic req_evt_o,
  output logic seq_err_o
);

  logic last_req_q, ack_q;
  logic changed;

  assign changed   = !hold_i && (req_ni != last_req_q);
  assign req_evt_o = changed && !req_ni && ack_q;
  assign seq_err_o = changed && !req_ni && !ack_q;
  assign ack_no    = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_req_q <= 1'b1;
      ack_q      <= 1'b1;
    end else begin
      if (changed) last_req_q <= req_ni;
      if (changed && req_ni && !ack_q) ack_q <= 1'b1;
      else if (req_evt_o)              ack_q <= 1'b0;
    end
  end

  AST_ACK_FALL_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> !$past(req_ni)); // R2
  AST_ACK_RISE_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_ni)); // R3
  AST_HOLD_FREEZES_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> $stable(ack_q)); // R8

endmodule

// File: rtl/hs_cmd_argbuf.sv
module hs_cmd_argbuf #(
  parameter int DEPTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         data_i,
  output logic [DEPTH*8-1:0] args_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          slot_q <= '0;
      else if (we_i && addr_i == 8'(g))     slot_q <= data_i;
    end
    assign args_o[g*8 +: 8] = slot_q;
  end

  AST_ARG_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> addr_i < 8'(DEPTH)); // R7

endmodule

// File: rtl/hs_cmd_rspbuf.sv
module hs_cmd_rspbuf #(
  parameter int DEPTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DEPTH*8-1:0] data_i,
  input  logic [7:0]         idx_i,
  output logic [7:0]         byte_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mem_q[g] <= '0;
      else if (load_i) mem_q[g] <= data_i[g*8 +: 8];
    end
  end

  assign byte_o = (idx_i < 8'(DEPTH)) ? mem_q[idx_i[AW-1:0]] : 8'h00;

endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine
  import hs_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_ni,
  output logic                   ack_no,
  input  logic                   sr_dir_i,
  input  logic [7:0]             sr_data_i,
  output logic [7:0]             sr_data_o,
  output logic                   sr_done_o,
  output logic                   proto_err_o,
  output logic                   disp_req_o,
  output logic [7:0]             disp_cmd_o,
  output logic [7:0]             disp_argc_o,
  output logic [BUF_DEPTH*8-1:0] disp_args_o,
  input  logic                   disp_ack_i,
  input  logic                   disp_known_i,
  input  logic [7:0]             disp_rsp_len_i,
  input  logic [BUF_DEPTH*8-1:0] disp_rsp_i
);

  localparam logic [7:0] DEPTH8 = 8'(BUF_DEPTH);

  eng_state_e state_q;
  logic [7:0] cmd_q, arg_len_q, arg_cnt_q, rsp_tbl_q, rsp_len_q, rsp_size_q, rsp_pos_q;
  logic       arg_var_q, rsp_var_q;
  logic [7:0] sr_out_q;
  logic       done_q, err_q;

  logic       ev, hs_err, arg_we, rsp_load;
  logic [7:0] rsp_byte, rsp_clamp;
  len_pair_t  tbl;

  assign tbl       = lookup_len(sr_data_i);
  assign rsp_clamp = (disp_rsp_len_i > DEPTH8) ? DEPTH8 : disp_rsp_len_i;
  assign arg_we    = ev && state_q == ST_CMD && sr_dir_i && !arg_var_q && arg_cnt_q < DEPTH8;
  assign rsp_load  = state_q == ST_DISP && disp_ack_i;

  hs_cmd_handshake u_hs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_ni    (req_ni),
    .hold_i    (state_q == ST_DISP),
    .ack_no    (ack_no),
    .req_evt_o (ev),
    .seq_err_o (hs_err)
  );

  hs_cmd_argbuf #(.DEPTH(BUF_DEPTH)) u_args (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (arg_we),
    .addr_i (arg_cnt_q),
    .data_i (sr_data_i),
    .args_o (disp_args_o)
  );

  hs_cmd_rspbuf #(.DEPTH(BUF_DEPTH)) u_rsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rsp_load),
    .data_i (disp_known_i ? disp_rsp_i : '0),
    .idx_i  (rsp_pos_q),
    .byte_o (rsp_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cmd_q      <= '0;
      arg_len_q  <= '0;
      arg_var_q  <= 1'b0;
      arg_cnt_q  <= '0;
      rsp_tbl_q  <= '0;
      rsp_len_q  <= '0;
      rsp_var_q  <= 1'b0;
      rsp_size_q <= '0;
      rsp_pos_q  <= '0;
      sr_out_q   <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= hs_err;
      case (state_q)
        ST_IDLE: if (ev) begin
          if (!sr_dir_i) err_q <= 1'b1;
          else begin
            done_q    <= 1'b1;
            cmd_q     <= sr_data_i;
            arg_len_q <= tbl.arg_len;
            arg_var_q <= (tbl.arg_len == LEN_VAR);
            rsp_tbl_q <= tbl.rsp_len;
            arg_cnt_q <= '0;
            rsp_pos_q <= '0;
            state_q   <= (tbl.arg_len == 8'd0) ? ST_DISP : ST_CMD;
          end
        end
        ST_CMD: if (ev) begin
          if (!sr_dir_i) err_q <= 1'b1;
          else begin
            done_q <= 1'b1;
            if (arg_var_q) begin
              arg_len_q <= sr_data_i;
              arg_var_q <= 1'b0;
              if (sr_data_i == 8'd0) state_q <= ST_DISP;
            end else begin
              arg_cnt_q <= arg_cnt_q + 8'd1;
              if (arg_cnt_q + 8'd1 == arg_len_q) state_q <= ST_DISP;
            end
          end
        end
        ST_DISP: if (disp_ack_i) begin
          rsp_pos_q <= '0;
          if (rsp_tbl_q == LEN_VAR) begin
            rsp_var_q  <= 1'b1;
            rsp_size_q <= disp_known_i ? rsp_clamp : 8'd0;
            state_q    <= ST_RSP;
          end else begin
            rsp_var_q <= 1'b0;
            rsp_len_q <= rsp_tbl_q;
            state_q   <= (rsp_tbl_q == 8'd0) ? ST_IDLE : ST_RSP;
          end
        end
        ST_RSP: if (ev) begin
          if (sr_dir_i) err_q <= 1'b1;
          else begin
            done_q <= 1'b1;
            if (rsp_var_q) begin
              sr_out_q  <= rsp_size_q;
              rsp_var_q <= 1'b0;
              rsp_len_q <= rsp_size_q;
              if (rsp_size_q == 8'd0) state_q <= ST_IDLE;
            end else begin
              sr_out_q  <= rsp_byte;
              rsp_pos_q <= rsp_pos_q + 8'd1;
              if (rsp_pos_q + 8'd1 == rsp_len_q) state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sr_data_o   = sr_out_q;
  assign sr_done_o   = done_q;
  assign proto_err_o = err_q;
  assign disp_req_o  = state_q == ST_DISP;
  assign disp_cmd_o  = cmd_q;
  assign disp_argc_o = arg_cnt_q;

  AST_DONE_WITH_ACK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_done_o |-> $fell(ack_no)); // R13
  AST_ERR_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !sr_done_o); // R12
  AST_OUT_ONLY_BLOCK_TO_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sr_data_o) |-> !$past(sr_dir_i)); // R9
  AST_DISP_WAITS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_req_o && !disp_ack_i |=> disp_req_o); // R8

endmodule

// File: tb/hs_cmd_engine_tb.sv
module hs_cmd_engine_tb;

  localparam int D = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_ni = 1'b1;
  logic ack_no;
  logic sr_dir_i = 1'b1;
  logic [7:0] sr_data_i = '0;
  logic [7:0] sr_data_o;
  logic sr_done_o, proto_err_o, disp_req_o;
  logic [7:0] disp_cmd_o, disp_argc_o;
  logic [D*8-1:0] disp_args_o;
  logic disp_ack_i = 1'b0;
  logic disp_known_i = 1'b1;
  logic [7:0] disp_rsp_len_i = '0;
  logic [D*8-1:0] disp_rsp_i = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  hs_cmd_engine #(.BUF_DEPTH(D)) u_dut (
    .clk_i, .rst_ni, .req_ni, .ack_no, .sr_dir_i, .sr_data_i, .sr_data_o,
    .sr_done_o, .proto_err_o, .disp_req_o, .disp_cmd_o, .disp_argc_o,
    .disp_args_o, .disp_ack_i, .disp_known_i, .disp_rsp_len_i, .disp_rsp_i
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one request/release cycle; returns what was seen one edge after the request
  task automatic host_byte(input bit dir, input logic [7:0] d, output logic [7:0] got,
                           output bit done, output bit err);
    @(negedge clk_i);
    sr_dir_i = dir; sr_data_i = d; req_ni = 1'b0;
    @(negedge clk_i);
    got = sr_data_o; done = sr_done_o; err = proto_err_o;
    req_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    logic [7:0] g; bit dn, er;
    host_byte(1'b1, d, g, dn, er);
    chk(dn && !er, tag, {dn, er}, 2'b10);
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    logic [7:0] g; bit dn, er;
    host_byte(1'b0, 8'h00, g, dn, er);
    chk(dn && !er && g == exp, tag, g, exp);
  endtask

  task automatic do_disp(input bit known, input logic [7:0] len, input logic [D*8-1:0] rsp);
    chk(disp_req_o == 1'b1, "R8 dispatch pending", disp_req_o, 1);
    chk(ack_no == 1'b0, "R8 ack held low", ack_no, 0);
    disp_known_i = known; disp_rsp_len_i = len; disp_rsp_i = rsp; disp_ack_i = 1'b1;
    @(negedge clk_i);
    disp_ack_i = 1'b0;
    @(negedge clk_i);
    chk(ack_no == 1'b1, "R3 deferred release", ack_no, 1);
  endtask

  task automatic t_reset();
    chk(ack_no == 1'b1, "R1 ack", ack_no, 1);
    chk(!sr_done_o && !proto_err_o && !disp_req_o, "R1 outputs",
        {sr_done_o, proto_err_o, disp_req_o}, 0);
  endtask

  task automatic t_level_and_one_arg();
    @(negedge clk_i);
    sr_dir_i = 1'b1; sr_data_i = 8'h10; req_ni = 1'b0;
    @(negedge clk_i);
    chk(sr_done_o && !ack_no, "R2 first edge", {sr_done_o, ack_no}, 2'b10);
    @(negedge clk_i);
    chk(!sr_done_o, "R2 level no repeat", sr_done_o, 0);
    @(negedge clk_i);
    chk(!sr_done_o && !ack_no, "R2 still once", {sr_done_o, ack_no}, 0);
    req_ni = 1'b1;
    @(negedge clk_i);
    chk(ack_no && !sr_done_o, "R3 release", {ack_no, sr_done_o}, 2'b10);
    wr(8'h5A, "R5 arg");
    chk(disp_cmd_o == 8'h10 && disp_argc_o == 8'd1, "R4 cmd10", {disp_cmd_o, disp_argc_o}, 16'h1001);
    chk(disp_args_o[7:0] == 8'h5A, "R5 arg0", disp_args_o[7:0], 8'h5A);
    do_disp(1'b1, 8'd0, '0);
    chk(!disp_req_o, "R9 zero rsp idle", disp_req_o, 0);
  endtask

  task automatic t_fixed_rsp();
    logic [D*8-1:0] r = '0;
    r[31:0] = 32'hD4C3B2A1;
    wr(8'h38, "R4 cmd38");
    chk(disp_cmd_o == 8'h38 && disp_argc_o == 0, "R4 immediate dispatch", disp_cmd_o, 8'h38);
    do_disp(1'b1, 8'd0, r);
    rd(8'hA1, "R9 b0"); rd(8'hB2, "R9 b1"); rd(8'hC3, "R9 b2"); rd(8'hD4, "R9 b3");
  endtask

  task automatic t_fixed_args();
    wr(8'h30, "R4 cmd30");
    wr(8'h11, "R5 a0"); wr(8'h22, "R5 a1"); wr(8'h33, "R5 a2");
    chk(!disp_req_o, "R5 not early", disp_req_o, 0);
    wr(8'h44, "R5 a3");
    chk(disp_argc_o == 8'd4 && disp_args_o[31:0] == 32'h44332211, "R5 args",
        disp_args_o[31:0], 32'h44332211);
    do_disp(1'b1, 8'd0, '0);
  endtask

  task automatic t_var_args_rsp();
    logic [D*8-1:0] r = '0;
    r[15:0] = 16'hBC9A;
    wr(8'h20, "R6 cmd"); wr(8'h03, "R6 count");
    wr(8'h05, "R6 a0"); wr(8'h06, "R6 a1");
    chk(!disp_req_o, "R6 not early", disp_req_o, 0);
    wr(8'h07, "R6 a2");
    chk(disp_argc_o == 8'd3 && disp_args_o[23:0] == 24'h070605, "R6 args",
        disp_args_o[23:0], 24'h070605);
    do_disp(1'b1, 8'd2, r);
    rd(8'h02, "R10 size"); rd(8'h9A, "R10 b0"); rd(8'hBC, "R10 b1");
  endtask

  task automatic t_var_zero();
    wr(8'h20, "R6 cmd"); wr(8'h00, "R6 zero count");
    chk(disp_req_o && disp_argc_o == 0, "R6 zero dispatch", disp_req_o, 1);
    do_disp(1'b1, 8'd0, '0);
    rd(8'h00, "R10 zero size");
  endtask

  task automatic t_overflow();
    wr(8'h20, "R7 cmd"); wr(8'd34, "R7 count");
    for (int i = 0; i < 34; i++) wr(8'h40 + 8'(i), "R7 byte");
    chk(disp_req_o && disp_argc_o == 8'd34, "R7 counted", disp_argc_o, 34);
    chk(disp_args_o[7:0] == 8'h40 && disp_args_o[255:248] == 8'h5F, "R7 stored",
        disp_args_o[255:248], 8'h5F);
    do_disp(1'b1, 8'd0, '0);
    rd(8'h00, "R7 size");
  endtask

  task automatic t_unknown();
    wr(8'h38, "R11 cmd38");
    do_disp(1'b0, 8'd4, {D{8'hEE}});
    for (int i = 0; i < 4; i++) rd(8'h00, "R11 zero fill");
    wr(8'h78, "R11 cmd78");
    do_disp(1'b0, 8'd5, {D{8'hEE}});
    rd(8'h00, "R11 empty var");
    chk(!disp_req_o, "R11 idle", disp_req_o, 0);
  endtask

  task automatic t_dir_err();
    logic [D*8-1:0] r = '0;
    logic [7:0] g; bit dn, er;
    r[31:0] = 32'h04030201;
    host_byte(1'b0, 8'h38, g, dn, er);
    chk(er && !dn, "R12 idle dir", {er, dn}, 2'b10);
    chk(!disp_req_o, "R12 idle stays", disp_req_o, 0);
    wr(8'h38, "R12 cmd after err");
    chk(disp_cmd_o == 8'h38, "R12 cmd taken", disp_cmd_o, 8'h38);
    do_disp(1'b1, 8'd0, r);
    rd(8'h01, "R12 b0");
    host_byte(1'b1, 8'h99, g, dn, er);
    chk(er && !dn, "R12 rsp dir", {er, dn}, 2'b10);
    rd(8'h02, "R12 not consumed");
    rd(8'h03, "R12 b2"); rd(8'h04, "R12 b3");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_level_and_one_arg();
    t_fixed_rsp();
    t_fixed_args();
    t_var_args_rsp();
    t_var_zero();
    t_overflow();
    t_unknown();
    t_dir_err();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule